// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

The walker follows a linked list of 32-byte transfer descriptors kept in a word-addressed memory. A one-cycle `go` pulse loads the first descriptor pointer. For each descriptor the walker reads the status/control word and checks that hardware owns the descriptor. It then reads the read address, write address, next pointer and length words and hands them to an external data mover through a one-cycle start and one-cycle done handshake. When the mover reports the bytes it moved and a status byte, the walker writes them back into the descriptor's last word, together with the control byte. It then moves on to the next pointer.

The chain ends at the first descriptor that hardware does not own, unless polling is enabled. With polling enabled, the walker waits a programmable number of clocks and reads the same descriptor again. A failing descriptor can also end the chain, when stop-on-error is set. The register block sees pulses for descriptor completion, error and chain end, and can read the current chain position at all times.

Descriptor words, by word index from the descriptor base: 0 read address, 2 write address, 4 next-descriptor byte pointer, 6 length in bits 15:0 (burst sizes in the upper bits are not used), 7 status/control word. Words 1, 3 and 5 are padding and are never accessed. In word 7, bits 15:0 are the transferred byte count, bits 23:16 the status byte and bits 31:24 the control byte. Control bits: 7 owned by hardware, 2 fixed write address, 1 fixed read address, 0 end of packet, and 6:3 a channel field that is written as zero. A status byte is an error when any of its bits 5:0 is set.

Top module: `dcw_chain_walker`

## Requirements
- R1: After synchronous reset, `busy`, `mem_req`, `mv_start` and all three event outputs are low, and `cur_ptr` is zero.
- R2: For each descriptor at byte pointer P, the walker reads word address P/4+7 first, then P/4+0, +2, +4 and +6, in that order. A request holds `mem_addr` and `mem_we` steady until it is acknowledged.
- R3: After the last fetch, `mv_start` pulses for one cycle with `mv_rd_addr` = word 0, `mv_wr_addr` = word 2, `mv_len` = word 6 bits 15:0, `mv_rd_fixed` = control bit 1 and `mv_wr_fixed` = control bit 2. No memory request is made until `mv_done`.
- R4: After `mv_done`, the walker writes word P/4+7 as {control', status, transferred count}. control' keeps all control bits, except that bit 7 is cleared when `cfg_keep_own` is 0 and left set when it is 1.
- R5: The cycle after the writeback is acknowledged, `evt_desc_done` pulses and `cur_ptr` takes the descriptor's word 4. The next fetch then starts at that pointer.
- R6: With polling off, a descriptor whose control bit 7 is clear ends the chain. `evt_chain_end` pulses once, `busy` drops, `cur_ptr` stays at that descriptor and no further memory request is issued.
- R7: With polling on, a non-owned descriptor is read again at the same address. `mem_req` stays low for exactly `cfg_poll_wait`+1 clocks between the two reads.
- R8: A writeback whose status has any of bits 5:0 set pulses `evt_error` together with `evt_desc_done`. With `cfg_stop_on_err` set, the chain then ends with `evt_chain_end`, `cur_ptr` is the failing descriptor's next pointer, and later descriptors stay untouched.
- R9: With `cfg_stop_on_err` clear, an erroring descriptor does not stop the chain.
- R10: A `go` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse from the register block |
| first_ptr | input | 32 | Byte pointer of the first descriptor |
| cfg_poll_en | input | 1 | Re-read non-owned descriptors |
| cfg_poll_wait | input | WAIT_W | Poll delay in clocks |
| cfg_stop_on_err | input | 1 | End chain after an erroring descriptor |
| cfg_keep_own | input | 1 | Leave ownership bit set on writeback |
| busy | output | 1 | Walker active |
| cur_ptr | output | 32 | Current descriptor byte pointer |
| evt_desc_done | output | 1 | Pulse per completed writeback |
| evt_error | output | 1 | Pulse for an erroring writeback |
| evt_chain_end | output | 1 | Pulse when the chain ends |
| mem_req | output | 1 | Memory request, held until ack |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| mv_start | output | 1 | Mover start pulse |
| mv_rd_addr | output | 32 | Source address |
| mv_wr_addr | output | 32 | Destination address |
| mv_len | output | 16 | Byte count |
| mv_rd_fixed | output | 1 | Source address fixed |
| mv_wr_fixed | output | 1 | Destination address fixed |
| mv_done | input | 1 | Mover finished pulse |
| mv_xfer | input | 16 | Bytes transferred |
| mv_status | input | 8 | Transfer status byte |

## Verification
The bench sweeps chains of one to four descriptors, placed at scattered slots. It crosses both ownership writeback modes with every error position and with stop-on-error on and off. A walker that stopped on any error regardless of the mode, or ran on past the failing descriptor, would leave later descriptors rewritten or untouched against expectation. A walker that dropped or misplaced the ownership clear would show a wrong control byte in memory. The bench measures the polling gap for zero, short and longer delays, where an off-by-one delay counter shows at once. It also sends a second `go` mid-chain, which a walker that reloaded its pointer would follow.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

    localparam int WORD_W   = 32;
    localparam int CNT_W    = 16;
    localparam int BYTE_W   = 8;

    // Word indices inside one descriptor (behavioural: fetch order and layout)
    localparam logic [2:0] WI_SRC  = 3'd0;
    localparam logic [2:0] WI_DST  = 3'd2;
    localparam logic [2:0] WI_LINK = 3'd4;
    localparam logic [2:0] WI_SIZE = 3'd6;
    localparam logic [2:0] WI_STAT = 3'd7;

    // Control byte bits
    localparam int CB_EOP   = 0;
    localparam int CB_SFIX  = 1;
    localparam int CB_DFIX  = 2;
    localparam int CB_HWOWN = 7;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_GET_CTL,
        WS_GET_BODY,
        WS_LAUNCH,
        WS_MOVING,
        WS_PUT_STAT,
        WS_WAIT_POLL
    } walk_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
        logic [WORD_W-1:0] link;
        logic [CNT_W-1:0]  size;
        logic [BYTE_W-1:0] ctl;
    } desc_t;

    function automatic logic is_fault(input logic [BYTE_W-1:0] st);
        return |st[5:0];
    endfunction

    function automatic logic [WORD_W-1:0] stat_word(
        input logic [CNT_W-1:0]  moved,
        input logic [BYTE_W-1:0] st,
        input logic [BYTE_W-1:0] ctl,
        input logic              keep_own
    );
        logic [BYTE_W-1:0] c;
        c = ctl;
        if (!keep_own) c[CB_HWOWN] = 1'b0;
        return {c, st, moved};
    endfunction

endpackage

// File: rtl/dcw_poll_timer.sv
module dcw_poll_timer #(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    output logic              expired
);
    logic [WAIT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)                 remain <= '0;
        else if (load)           remain <= load_val;
        else if (remain != '0)   remain <= remain - 1'b1;
    end

    assign expired = (remain == '0);

    assert_count_down_R7: assert property (@(posedge clk) disable iff (rst)
        (!load && remain != '0) |=> (remain == $past(remain) - 1'b1));

    assert_load_R7: assert property (@(posedge clk) disable iff (rst)
        load |=> (remain == $past(load_val)));
endmodule

// File: rtl/dcw_desc_capture.sv
module dcw_desc_capture
    import dcw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic              body_we,
    input  logic [1:0]        body_sel,
    input  logic [WORD_W-1:0] rdata,
    output desc_t             desc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            desc <= '0;
        end else begin
            if (ctl_we) desc.ctl <= rdata[WORD_W-1 -: BYTE_W];
            if (body_we) begin
                case (body_sel)
                    2'd0:    desc.src  <= rdata;
                    2'd1:    desc.dst  <= rdata;
                    2'd2:    desc.link <= rdata;
                    default: desc.size <= rdata[CNT_W-1:0];
                endcase
            end
        end
    end
endmodule

// File: rtl/dcw_wb_pack.sv
module dcw_wb_pack
    import dcw_pkg::*;
(
    input  logic [CNT_W-1:0]  moved,
    input  logic [BYTE_W-1:0] st,
    input  logic [BYTE_W-1:0] ctl,
    input  logic              keep_own,
    output logic [WORD_W-1:0] word,
    output logic              fault
);
    always_comb begin
        word  = stat_word(moved, st, ctl, keep_own);
        fault = is_fault(st);
    end
endmodule

// File: rtl/dcw_chain_walker.sv
module dcw_chain_walker
    import dcw_pkg::*;
#(
    parameter int AW     = 16,
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [31:0]       first_ptr,
    input  logic              cfg_poll_en,
    input  logic [WAIT_W-1:0] cfg_poll_wait,
    input  logic              cfg_stop_on_err,
    input  logic              cfg_keep_own,
    output logic              busy,
    output logic [31:0]       cur_ptr,
    output logic              evt_desc_done,
    output logic              evt_error,
    output logic              evt_chain_end,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              mv_start,
    output logic [31:0]       mv_rd_addr,
    output logic [31:0]       mv_wr_addr,
    output logic [15:0]       mv_len,
    output logic              mv_rd_fixed,
    output logic              mv_wr_fixed,
    input  logic              mv_done,
    input  logic [15:0]       mv_xfer,
    input  logic [7:0]        mv_status
);
    localparam int BODY_N = 4;
    localparam int SEL_W  = $clog2(BODY_N);
    localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(BODY_N - 1);

    walk_state_t       state;
    logic [SEL_W-1:0]  body_sel;
    logic [CNT_W-1:0]  moved_q;
    logic [BYTE_W-1:0] st_q;
    logic [2:0]        word_off;
    logic              owned;
    logic              poll_load;
    logic              poll_done;
    logic [WORD_W-1:0] wb_word;
    logic              wb_fault;
    desc_t             desc;

    // Word offset of the access in flight
    always_comb begin
        case (body_sel)
            2'd0:    word_off = WI_SRC;
            2'd1:    word_off = WI_DST;
            2'd2:    word_off = WI_LINK;
            default: word_off = WI_SIZE;
        endcase
        if (state != WS_GET_BODY) word_off = WI_STAT;
    end

    assign owned     = mem_rdata[24 + CB_HWOWN];
    assign poll_load = (state == WS_GET_CTL) && mem_ack && !owned && cfg_poll_en;

    assign busy      = (state != WS_IDLE);
    assign mem_req   = (state == WS_GET_CTL) || (state == WS_GET_BODY) || (state == WS_PUT_STAT);
    assign mem_we    = (state == WS_PUT_STAT);
    assign mem_addr  = cur_ptr[AW+1:2] + AW'(word_off);
    assign mem_wdata = wb_word;
    assign mv_start  = (state == WS_LAUNCH);

    assign mv_rd_addr  = desc.src;
    assign mv_wr_addr  = desc.dst;
    assign mv_len      = desc.size;
    assign mv_rd_fixed = desc.ctl[CB_SFIX];
    assign mv_wr_fixed = desc.ctl[CB_DFIX];

    dcw_desc_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .ctl_we   ((state == WS_GET_CTL) && mem_ack),
        .body_we  ((state == WS_GET_BODY) && mem_ack),
        .body_sel (body_sel),
        .rdata    (mem_rdata),
        .desc     (desc)
    );

    dcw_wb_pack u_pack (
        .moved    (moved_q),
        .st       (st_q),
        .ctl      (desc.ctl),
        .keep_own (cfg_keep_own),
        .word     (wb_word),
        .fault    (wb_fault)
    );

    dcw_poll_timer #(.WAIT_W(WAIT_W)) u_poll (
        .clk      (clk),
        .rst      (rst),
        .load     (poll_load),
        .load_val (cfg_poll_wait),
        .expired  (poll_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= WS_IDLE;
            cur_ptr       <= '0;
            body_sel      <= '0;
            moved_q       <= '0;
            st_q          <= '0;
            evt_desc_done <= 1'b0;
            evt_error     <= 1'b0;
            evt_chain_end <= 1'b0;
        end else begin
            evt_desc_done <= 1'b0;
            evt_error     <= 1'b0;
            evt_chain_end <= 1'b0;
            case (state)
                WS_IDLE: begin
                    if (go) begin
                        cur_ptr <= first_ptr;
                        state   <= WS_GET_CTL;
                    end
                end
                WS_GET_CTL: begin
                    if (mem_ack) begin
                        if (owned) begin
                            body_sel <= '0;
                            state    <= WS_GET_BODY;
                        end else if (cfg_poll_en) begin
                            state <= WS_WAIT_POLL;
                        end else begin
                            evt_chain_end <= 1'b1;
                            state         <= WS_IDLE;
                        end
                    end
                end
                WS_GET_BODY: begin
                    if (mem_ack) begin
                        if (body_sel == LAST_SEL) state <= WS_LAUNCH;
                        else                      body_sel <= body_sel + 1'b1;
                    end
                end
                WS_LAUNCH: state <= WS_MOVING;
                WS_MOVING: begin
                    if (mv_done) begin
                        moved_q <= mv_xfer;
                        st_q    <= mv_status;
                        state   <= WS_PUT_STAT;
                    end
                end
                WS_PUT_STAT: begin
                    if (mem_ack) begin
                        evt_desc_done <= 1'b1;
                        evt_error     <= wb_fault;
                        cur_ptr       <= desc.link;
                        if (cfg_stop_on_err && wb_fault) begin
                            evt_chain_end <= 1'b1;
                            state         <= WS_IDLE;
                        end else begin
                            state <= WS_GET_CTL;
                        end
                    end
                end
                WS_WAIT_POLL: begin
                    if (poll_done) state <= WS_GET_CTL;
                end
                default: state <= WS_IDLE;
            endcase
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!busy && !mem_req && !mv_start && cur_ptr == '0));

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        mv_start |=> (!mv_start && !mem_req));

    assert_own_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && !cfg_keep_own) |-> !mem_wdata[31]);

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        evt_desc_done |=> !evt_desc_done);

    assert_idle_silent_R6: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !mv_start));

    assert_err_with_done_R8: assert property (@(posedge clk) disable iff (rst)
        evt_error |-> evt_desc_done);

    assert_go_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && go && !evt_desc_done) |=> $stable(cur_ptr) || evt_desc_done);
endmodule

// File: tb/test_dcw_chain_walker.sv
module test_dcw_chain_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        go = 1'b0;
    logic [31:0] first_ptr = '0;
    logic        cfg_poll_en = 1'b0;
    logic [7:0]  cfg_poll_wait = '0;
    logic        cfg_stop_on_err = 1'b0;
    logic        cfg_keep_own = 1'b0;
    logic        busy, evt_desc_done, evt_error, evt_chain_end;
    logic [31:0] cur_ptr;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mv_start, mv_rd_fixed, mv_wr_fixed;
    logic [31:0] mv_rd_addr, mv_wr_addr;
    logic [15:0] mv_len;
    logic        mv_done = 1'b0;
    logic [15:0] mv_xfer = '0;
    logic [7:0]  mv_status = '0;

    always #10 clk = ~clk;

    dcw_chain_walker i_dcw_chain_walker (
        .clk(clk), .rst(rst), .go(go), .first_ptr(first_ptr),
        .cfg_poll_en(cfg_poll_en), .cfg_poll_wait(cfg_poll_wait),
        .cfg_stop_on_err(cfg_stop_on_err), .cfg_keep_own(cfg_keep_own),
        .busy(busy), .cur_ptr(cur_ptr), .evt_desc_done(evt_desc_done),
        .evt_error(evt_error), .evt_chain_end(evt_chain_end),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mv_start(mv_start), .mv_rd_addr(mv_rd_addr), .mv_wr_addr(mv_wr_addr),
        .mv_len(mv_len), .mv_rd_fixed(mv_rd_fixed), .mv_wr_fixed(mv_wr_fixed),
        .mv_done(mv_done), .mv_xfer(mv_xfer), .mv_status(mv_status)
    );

    int n_chk = 0;
    int n_fail = 0;
    int err_at = 99;      // descriptor index whose transfer reports an error
    logic clr = 1'b0;

    logic [31:0] mem [0:63];

    // memory model: one-cycle registered acknowledge
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[5:0]];
        end
    end

    // logs and event counters
    logic [15:0] rdlog [0:63];
    int rd_n, acc_n, done_n, err_n, end_n, mv_n;
    logic [31:0] lg_src [0:7];
    logic [31:0] lg_dst [0:7];
    logic [15:0] lg_len [0:7];
    logic [1:0]  lg_fix [0:7];
    int mv_cnt = 0;

    always @(posedge clk) begin
        if (clr) begin
            rd_n <= 0; acc_n <= 0; done_n <= 0; err_n <= 0; end_n <= 0; mv_n <= 0;
        end else begin
            if (mem_req && mem_ack) acc_n <= acc_n + 1;
            if (mem_req && mem_ack && !mem_we && rd_n < 64) begin
                rdlog[rd_n] <= mem_addr;
                rd_n <= rd_n + 1;
            end
            if (evt_desc_done) done_n <= done_n + 1;
            if (evt_error)     err_n  <= err_n + 1;
            if (evt_chain_end) end_n  <= end_n + 1;
            if (mv_start && mv_n < 8) begin
                lg_src[mv_n] <= mv_rd_addr;
                lg_dst[mv_n] <= mv_wr_addr;
                lg_len[mv_n] <= mv_len;
                lg_fix[mv_n] <= {mv_wr_fixed, mv_rd_fixed};
                mv_xfer   <= mv_len - 16'(mv_n);
                mv_status <= (mv_n == err_at) ? 8'h88 : 8'h80;
                mv_n <= mv_n + 1;
            end
        end
    end

    // mover model: done two cycles after start
    always @(posedge clk) begin
        if (mv_start)        mv_cnt <= 2;
        else if (mv_cnt != 0) mv_cnt <= mv_cnt - 1;
        mv_done <= (mv_cnt == 1);
    end

    // low-gap monitor on mem_req
    int lowcnt = 0;
    int last_gap = 0;
    always @(negedge clk) begin
        if (!mem_req) lowcnt <= lowcnt + 1;
        else begin
            if (lowcnt > 0) last_gap <= lowcnt;
            lowcnt <= 0;
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            $display("FAIL watchdog: actual cycle %0d expected < 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail + 1);
            $finish;
        end
    end

    function automatic int slot_of(int i);
        return (i * 3 + 1) % 8;
    endfunction
    function automatic logic [31:0] ptr_of(int i);
        return 32'(slot_of(i) * 32);
    endfunction
    function automatic logic [7:0] ctl_of(int i, int run);
        return 8'h80 | 8'((i + run) % 8);
    endfunction
    function automatic logic [15:0] len_of(int i, int run);
        return 16'(16'h0100 + i * 16 + run);
    endfunction
    function automatic logic [31:0] init_w7(int i, int run);
        return {ctl_of(i, run), 8'h00, 16'hBEEF};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic build(input int len, input int run);
        for (int k = 0; k < 64; k++) mem[k] = 32'hDEAD_0000 + 32'(k);
        for (int i = 0; i <= len; i++) begin
            int b = slot_of(i) * 8;
            mem[b + 0] = 32'h1000_0000 + 32'(i * 256 + run);
            mem[b + 2] = 32'h2000_0000 + 32'(i * 512 + run);
            mem[b + 4] = ptr_of(i + 1);
            mem[b + 6] = {8'h22, 8'h11, len_of(i, run)};
            mem[b + 7] = (i < len) ? init_w7(i, run) : {8'(run % 8) & 8'h07, 8'h00, 16'hBEEF};
        end
    endtask

    task automatic pulse_go(input logic [31:0] p);
        @(negedge clk); first_ptr = p; go = 1'b1;
        @(negedge clk); go = 1'b0;
    endtask

    task automatic wait_end(input string req);
        int t = 0;
        while (end_n == 0 && t < 3000) begin @(negedge clk); t++; end
        chk(end_n != 0, req, 32'(end_n), 32'd1);
    endtask

    task automatic run_chain(input int len, input int run, input bit keep,
                             input bit stop, input int eidx, input bit rego);
        int p;
        int base0;
        logic [31:0] w;
        int quiet;
        build(len, run);
        cfg_keep_own = keep; cfg_stop_on_err = stop; cfg_poll_en = 1'b0;
        err_at = eidx;
        @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
        pulse_go(ptr_of(0));
        if (rego) begin
            repeat (6) @(negedge clk);
            pulse_go(ptr_of(6));   // R10: ignored while busy
        end
        wait_end("R6 chain end");
        p = (stop && eidx < len) ? eidx + 1 : len;
        base0 = slot_of(0) * 8;
        // R2 fetch order
        chk(rdlog[0] == 16'(base0 + 7) && rdlog[1] == 16'(base0) && rdlog[2] == 16'(base0 + 2) &&
            rdlog[3] == 16'(base0 + 4) && rdlog[4] == 16'(base0 + 6),
            "R2 fetch order", {rdlog[0], rdlog[4]}, {16'(base0 + 7), 16'(base0 + 6)});
        for (int i = 0; i < p; i++) begin
            logic [7:0] c;
            logic [7:0] s;
            c = ctl_of(i, run);
            chk(lg_src[i] == 32'h1000_0000 + 32'(i * 256 + run) &&
                lg_dst[i] == 32'h2000_0000 + 32'(i * 512 + run) &&
                lg_len[i] == len_of(i, run) && lg_fix[i] == {c[2], c[1]},
                "R3 mover handoff", lg_src[i], 32'h1000_0000 + 32'(i * 256 + run));
            if (!keep) c[7] = 1'b0;
            s = (i == eidx) ? 8'h88 : 8'h80;
            w = {c, s, len_of(i, run) - 16'(i)};
            chk(mem[slot_of(i) * 8 + 7] == w, (i == eidx) ? "R9 writeback" : "R4 writeback",
                mem[slot_of(i) * 8 + 7], w);
        end
        for (int i = p; i < len; i++)
            chk(mem[slot_of(i) * 8 + 7] == init_w7(i, run), "R8 untouched after stop",
                mem[slot_of(i) * 8 + 7], init_w7(i, run));
        chk(done_n == p, "R5 done count", 32'(done_n), 32'(p));
        chk(cur_ptr == ptr_of(p), rego ? "R10 pointer after ignored go" : "R5 cur_ptr",
            cur_ptr, ptr_of(p));
        chk(err_n == ((eidx < p) ? 1 : 0), "R8 error events", 32'(err_n), 32'((eidx < p) ? 1 : 0));
        quiet = acc_n;
        repeat (8) @(negedge clk);
        chk(end_n == 1 && !busy && acc_n == quiet, "R6 idle after end",
            {busy, 31'(end_n)}, 32'd1);
    endtask

    task automatic run_poll(input int wt, input int run);
        int b;
        build(1, run);
        b = slot_of(0) * 8;
        mem[b + 7][31] = 1'b0;
        cfg_poll_en = 1'b1; cfg_poll_wait = 8'(wt); cfg_keep_own = 1'b0; cfg_stop_on_err = 1'b0;
        err_at = 99;
        @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
        pulse_go(ptr_of(0));
        begin
            int t = 0;
            while (rd_n < 3 && t < 3000) begin @(negedge clk); t++; end
        end
        chk(last_gap == wt + 1, "R7 poll gap", 32'(last_gap), 32'(wt + 1));
        chk(rdlog[1] == 16'(b + 7) && rdlog[2] == 16'(b + 7) && done_n == 0,
            "R7 same descriptor", {16'(done_n), rdlog[2]}, 32'(b + 7));
        mem[b + 7][31] = 1'b1;
        cfg_poll_en = 1'b0;
        wait_end("R6 end after poll");
        chk(done_n == 1 && mem[b + 7] == {ctl_of(0, run) & 8'h7F, 8'h80, len_of(0, run)},
            "R7 processed after ownership", mem[b + 7], {ctl_of(0, run) & 8'h7F, 8'h80, len_of(0, run)});
    endtask

    initial begin
        int run = 0;
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req && !mv_start && !evt_desc_done && !evt_error && !evt_chain_end &&
            cur_ptr == 0, "R1 reset state", cur_ptr, 32'd0);
        rst = 1'b0;
        for (int keep = 0; keep < 2; keep++)
            for (int len = 1; len <= 4; len++)
                for (int e = -1; e < len; e++)
                    for (int stop = 0; stop < 2; stop++) begin
                        run_chain(len, run, keep[0], stop[0], (e < 0) ? 99 : e,
                                  (run % 7) == 3);
                        run++;
                    end
        run_poll(0, run++);
        run_poll(3, run++);
        run_poll(9, run++);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule